// File: doc/BRIEF.md
# Multiphase Gate Pulse Sequencer

This block turns the evenly spaced phases of a differential ring clock into a train of gate enables. Only one enable is high in each phase slot, and each pulse lasts exactly one slot, which is one twelfth of the ring period. The ring is modelled as a six-stage twisted-ring (Johnson) register. Each step of that register stands for one advance of the oscillator by a twelfth of its period. The advance strobe `adv_i` stands in for the tunable oscillator rate: a strobe on every clock gives the fastest rate, and sparser strobes give slower rates. Each gate pulse is formed by combining two neighbouring phase taps through an XNOR, so no divided clock or binary slot decoder is needed.

Several identical driver lanes share a single start request. The request is synchronised once, and every lane sees the same synchronised copy. Lanes acknowledge the request only at the boundary between the last slot and slot 0. As a result, every lane opens with gate 0 and all lanes run in lockstep. When the request is withdrawn, the current period runs to its end and the lanes then go quiet. The control pins are plain level signals with no handshake, because the block neither accepts nor emits a data stream.

Top module: `gate_pulse_seq`

## Requirements
- R1: After reset, and while the reset input is held low, every gate output is low and the ring stands at slot 0.
- R2: While a lane is running, exactly one of its PHASES gate outputs is high. At all other times none is high.
- R3: Gate k of a lane is high only while the ring is in slot k. Each pulse therefore lasts one advance, which is one twelfth of the period when the ring has 6 stages.
- R4: After an idle interval, the first pulse in each lane is always gate 0 (output bit 0 of the lane).
- R5: `start_i` is seen through SYNC_STAGES register stages. A lane starts running on the first advance from the last slot to slot 0 that happens once the synchronised start is high.
- R6: When the synchronised start is low at the advance out of the last slot (gate PHASES-1), all gates go low and stay low. The period that is already running always finishes.
- R7: In a cycle where `adv_i` is low, no gate output changes on the next clock edge.
- R8: Every lane drives the same gate pattern on the same cycle. Lane n occupies bits [n*PHASES +: PHASES] of `gate_o`.
- R9: While the synchronised start is low and the lanes are idle, all gates stay low.
- R10: While a lane is running, an advance moves the high gate from bit k to bit k+1, and from the last bit to bit 0 if the lane keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Asynchronous run request shared by all lanes |
| adv_i | input | 1 | Ring advance strobe: one pulse moves the ring one phase slot |
| gate_o | output | LANES*2*RING_STAGES | One-hot gate enables, PHASES bits per lane, with bit 0 the first gate |

## Verification
A ring register that holds a wrong value shows up as soon as the lane runs. Gates then appear two at a time, drop out for some slots, or come in the wrong order. The bench compares the full output vector on every cycle, so such a fault is caught on the first running cycle. A run flag that changes at the wrong time shows up within one slot: the sequence opens on a gate other than 0, or it stops in the middle of a period. An error in the synchroniser depth moves the first pulse by a whole period, which becomes visible at the very next period boundary. The sweep covers every start and stop offset across the twelve slots at three advance rates, plus an irregular advance pattern.

// File: rtl/gps_pkg.sv
package gps_pkg;

  typedef enum logic {
    GPS_IDLE = 1'b0,
    GPS_RUN  = 1'b1
  } gps_state_e;

  // index of the tap one phase behind tap j on a ring of n taps
  function automatic int gps_prev(input int j, input int n);
    return (j + n - 1) % n;
  endfunction

endpackage

// File: rtl/gps_start_sync.sv
module gps_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic req_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], req_i};
  end

  assign req_o = chain_q[STAGES-1];
endmodule

// File: rtl/gps_ring.sv
module gps_ring #(
  parameter  int STAGES = 6,
  localparam int PHASES = 2 * STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [PHASES-1:0] tap_o
);
  logic [STAGES-1:0] stg_q;

  // twisted ring: each stage copies its neighbour, the first takes the inverted last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stg_q <= '0;
    else if (adv_i) stg_q <= {stg_q[STAGES-2:0], ~stg_q[STAGES-1]};
  end

  // true outputs give the first half of the taps, complements the second half
  assign tap_o = {~stg_q, stg_q};
endmodule

// File: rtl/gps_combine.sv
module gps_combine #(
  parameter int PHASES = 12
) (
  input  logic [PHASES-1:0] tap_i,
  output logic [PHASES-1:0] slot_o
);
  logic [PHASES-1:0] agree;

  for (genvar j = 0; j < PHASES; j++) begin : g_pair
    localparam int PREV = gps_pkg::gps_prev(j, PHASES);
    // neighbouring taps disagree in two slots per period; the leading tap picks one
    assign agree[j]  = tap_i[PREV] ~^ tap_i[j];
    assign slot_o[j] = tap_i[PREV] & ~agree[j];
  end
endmodule

// File: rtl/gps_lane.sv
module gps_lane #(
  parameter  int STAGES = 6,
  localparam int PHASES = 2 * STAGES,
  localparam int LAST   = PHASES - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              start_i,
  output logic [PHASES-1:0] gate_o
);
  import gps_pkg::*;

  logic [PHASES-1:0] taps;
  logic [PHASES-1:0] slot;
  gps_state_e        state_q;

  gps_ring #(.STAGES(STAGES)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv_i),
    .tap_o  (taps)
  );

  gps_combine #(.PHASES(PHASES)) u_comb (
    .tap_i  (taps),
    .slot_o (slot)
  );

  // run decision is taken only at the wrap from the last slot back to slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GPS_IDLE;
    else if (adv_i && slot[LAST]) state_q <= start_i ? GPS_RUN : GPS_IDLE;
  end

  assign gate_o = (state_q == GPS_RUN) ? slot : '0;
endmodule

// File: rtl/gate_pulse_seq.sv
module gate_pulse_seq #(
  parameter  int LANES       = 2,
  parameter  int RING_STAGES = 6,
  parameter  int SYNC_STAGES = 2,
  localparam int PHASES      = 2 * RING_STAGES,
  localparam int GATES_W     = LANES * PHASES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               adv_i,
  output logic [GATES_W-1:0] gate_o
);
  logic start_sync;

  gps_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (start_i),
    .req_o  (start_sync)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gps_lane #(.STAGES(RING_STAGES)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (adv_i),
      .start_i (start_sync),
      .gate_o  (gate_o[l*PHASES +: PHASES])
    );
  end
endmodule

// File: rtl/gate_pulse_seq_chk.sv
module gate_pulse_seq_chk #(
  parameter  int LANES       = 2,
  parameter  int RING_STAGES = 6,
  localparam int PHASES      = 2 * RING_STAGES,
  localparam int GATES_W     = LANES * PHASES,
  localparam int LAST        = PHASES - 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               adv_i,
  input logic               start_s,
  input logic [GATES_W-1:0] gate_o
);
  logic [PHASES-1:0] lane0;
  assign lane0 = gate_o[PHASES-1:0];

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane0));

  a_r3_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && lane0 != '0) |=> (lane0 != $past(lane0)));

  a_r10_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && lane0 != '0 && !lane0[LAST]) |=> (lane0 == ($past(lane0) << 1)));

  a_r4_first_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|lane0) |-> lane0[0]);

  a_r6_stop_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && lane0[LAST] && !start_s) |=> (lane0 == '0));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(gate_o));

  a_r9_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane0 == '0 && !start_s) |=> (lane0 == '0));

  for (genvar l = 1; l < LANES; l++) begin : g_same
    a_r8_lanes_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_o[l*PHASES +: PHASES] == lane0);
  end
endmodule

bind gate_pulse_seq gate_pulse_seq_chk #(
  .LANES       (LANES),
  .RING_STAGES (RING_STAGES)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .adv_i   (adv_i),
  .start_s (start_sync),
  .gate_o  (gate_o)
);

// File: tb/sim_gate_pulse_seq.sv
`timescale 1ns/1ps
module sim_gate_pulse_seq;
  localparam int LANES = 2;
  localparam int RS    = 6;
  localparam int SS    = 2;
  localparam int P     = 2 * RS;
  localparam int W     = LANES * P;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         adv = 1'b0;
  logic [W-1:0] gate;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int           m_slot = 0;
  logic [SS-1:0] m_sync = '0;
  logic         m_run = 1'b0;
  logic [W-1:0] prev_gate = '0;
  int           tick = 0;

  always #2.5 clk = ~clk;

  gate_pulse_seq #(.LANES(LANES), .RING_STAGES(RS), .SYNC_STAGES(SS)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .adv_i   (adv),
    .gate_o  (gate)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expected();
    logic [P-1:0] one = {{(P-1){1'b0}}, 1'b1};
    logic [P-1:0] l = m_run ? (one << m_slot) : '0;
    return {LANES{l}};
  endfunction

  task automatic step(input logic st, input logic av);
    logic nrun;
    logic [W-1:0] e;
    logic [P-1:0] cur;
    logic [P-1:0] old;
    start = st;
    adv = av;
    @(posedge clk);
    #1;
    nrun = m_run;
    if (av && m_slot == P - 1) nrun = m_sync[SS-1];
    if (av) m_slot = (m_slot + 1) % P;
    m_sync = {m_sync[SS-2:0], st};
    m_run = nrun;
    e = expected();
    cur = gate[P-1:0];
    old = prev_gate[P-1:0];
    chk(gate == e, "R3/R5/R10 pattern", gate, e);
    chk($countones(cur) == (m_run ? 1 : 0), "R2 onehot", gate, e);
    for (int l = 1; l < LANES; l++)
      chk(gate[l*P +: P] == cur, "R8 lanes", gate, {LANES{cur}});
    if (!av) chk(gate == prev_gate, "R7 hold", gate, prev_gate);
    if (old == '0 && cur != '0) chk(cur[0], "R4 first gate", gate, e);
    if (old != '0 && cur == '0) chk(old[P-1], "R6 full period", prev_gate, e);
    if (!m_run) chk(gate == '0, "R9 idle", gate, '0);
    prev_gate = gate;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    adv = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(gate == '0, "R1 reset", gate, '0);
    m_slot = 0; m_sync = '0; m_run = 1'b0; prev_gate = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] lfsr;
    do_reset();
    // R1: ring begins at slot 0, so a start right after reset opens exactly as the model says
    for (int i = 0; i < 3 * P; i++) step(1'b1, 1'b1);
    do_reset();
    for (int div = 1; div <= 3; div++) begin
      for (int off = 0; off < P; off++) begin
        for (int i = 0; i < off; i++) begin step(1'b0, (tick % div) == 0); tick++; end
        for (int i = 0; i < (2 * P + off) * div; i++) begin step(1'b1, (tick % div) == 0); tick++; end
        for (int i = 0; i < (P + SS + 2) * div + off; i++) begin step(1'b0, (tick % div) == 0); tick++; end
      end
    end
    // irregular advance pattern with start toggling
    lfsr = 8'h5a;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((i % 97) < 60, lfsr[0] | lfsr[2]);
    end
    // R1: reset in the middle of a run clears every gate
    for (int i = 0; i < P + 5; i++) step(1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < P; i++) step(1'b0, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule